// File: doc/BRIEF.md
# Virtual Processor Run/Stop Controller

This block sits beside a cluster of virtual processors (VPs) and lets software start and halt them through a small register space. Software writes a bitmask to a start register to ask selected VPs to reset and begin running, and writes a bitmask to a halt register to ask them to stop. A status register reports which VPs are running. A VP counts as running only once it has acknowledged the reset request, so the status reflects processors that have actually come up, not ones that have merely been asked.

The register set is visible at two bases, a local window and a window used by another core. Both windows reach the same state. Out of reset the status is empty, and the block then issues a start to a parameter-selected set of VPs with no software involvement. The bus port takes one access per cycle with no back-pressure: a read returns its data exactly one cycle later, flagged by a read-valid pulse. The per-VP request and acknowledge pins are plain control signals.

Top module: `vp_run_ctrl`

## Requirements
- R1: While reset is asserted, all start and halt requests, the read-valid flag and the read data are zero, and the running status is empty.
- R2: In the first cycle after reset is released, a one-cycle start pulse goes to every VP set in the BOOT_MASK parameter; the running status stays clear until those VPs acknowledge.
- R3: A write to the start register raises, in the next cycle and for one cycle only, a start pulse on each VP whose bit is 1 in the written data and 0 in the running status.
- R4: A VP's running bit is set by its start-acknowledge input at the edge where that input is high, and never by a write to the start register.
- R5: A write to the halt register raises, in the next cycle for one cycle, a halt pulse on each VP whose bit is 1 in the data and 1 in the running status, and clears those running bits at the same edge; VPs not running get no pulse.
- R6: A halt write covering a VP takes priority over that VP's acknowledge in the same cycle: its running bit ends clear.
- R7: Written data bits at positions NUM_VP and above are ignored, and read data bits at those positions are always zero.
- R8: The start, halt and status registers respond identically at offsets 0x28, 0x30 and 0x38 above both LOCAL_BASE and REMOTE_BASE.
- R9: A read returns, with read-valid high, one cycle after it is presented, the running status (bit n = VP n) for the status offset and zero for any other offset; writes to any other offset change nothing, and read data is zero whenever read-valid is low.
- R10: A BOOT_MASK with any bit set at or above NUM_VP is rejected as a configuration error at start of simulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_vld | input | 1 | Access present this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 64 | Write data, one bit per VP |
| bus_rdata | output | 64 | Read data, one cycle after the read |
| bus_rvld | output | 1 | Read data valid |
| vp_start_req | output | NUM_VP | One-cycle reset-and-start request per VP |
| vp_halt_req | output | NUM_VP | One-cycle halt request per VP |
| vp_start_ack | input | NUM_VP | VP has left reset and is running |

## Verification
Every result of this block lands exactly one clock edge after its cause: start and halt pulses, read data and read-valid all appear in the cycle following the access, and an acknowledge changes the status at the edge it is sampled on, so a read issued the next cycle returns it one cycle later again. The bench drives inputs on the falling edge and holds a behavioural model that advances on each rising edge, so it compares every output on the following falling edge, one full register stage after the stimulus. Directed checks at the same sampling point cover the boot pulse, pulse width, masking, both windows, halt-versus-acknowledge priority and unmapped offsets.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  // Decoded access for one bus cycle
  typedef struct packed {
    logic go_wr;    // write to start register
    logic halt_wr;  // write to halt register
    logic stat_rd;  // read of status register
    logic any_rd;   // any read
  } vpc_op_t;

  localparam int unsigned DATA_W = 64;
endpackage

// File: rtl/vpc_decode.sv
module vpc_decode
  import vpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LOCAL_BASE  = 'h2000,
  parameter logic [ADDR_W-1:0] REMOTE_BASE = 'h4000,
  parameter logic [ADDR_W-1:0] GO_OFS   = 'h0028,
  parameter logic [ADDR_W-1:0] HALT_OFS = 'h0030,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h0038
) (
  input  logic              vld,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output vpc_op_t           op
);
  localparam int unsigned NWIN = 2;
  localparam logic [NWIN-1:0][ADDR_W-1:0] BASES = {REMOTE_BASE, LOCAL_BASE};

  logic [NWIN-1:0] hit_go, hit_halt, hit_stat;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign hit_go[w]   = (addr == BASES[w] + GO_OFS);
    assign hit_halt[w] = (addr == BASES[w] + HALT_OFS);
    assign hit_stat[w] = (addr == BASES[w] + STAT_OFS);
  end

  always_comb begin
    op.go_wr   = vld &  wr & (|hit_go);
    op.halt_wr = vld &  wr & (|hit_halt);
    op.stat_rd = vld & ~wr & (|hit_stat);
    op.any_rd  = vld & ~wr;
  end
endmodule

// File: rtl/vpc_state.sv
module vpc_state #(
  parameter int unsigned NUM_VP = 1,
  parameter logic [63:0] BOOT_MASK = 64'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_wr,
  input  logic              halt_wr,
  input  logic [NUM_VP-1:0] wmask,
  input  logic [NUM_VP-1:0] ack,
  output logic [NUM_VP-1:0] running,
  output logic [NUM_VP-1:0] start_q,
  output logic [NUM_VP-1:0] halt_q
);
  logic boot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end

  for (genvar i = 0; i < NUM_VP; i++) begin : g_vp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        running[i] <= 1'b0;
        start_q[i] <= 1'b0;
        halt_q[i]  <= 1'b0;
      end else begin
        start_q[i] <= (boot_q & BOOT_MASK[i]) | (go_wr & wmask[i] & ~running[i]);
        halt_q[i]  <= halt_wr & wmask[i] & running[i];
        if (halt_wr & wmask[i]) running[i] <= 1'b0;   // halt beats ack
        else if (ack[i])        running[i] <= 1'b1;
      end
    end

    // R4: status only rises on an acknowledge
    p_rise_by_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running[i]) |-> $past(ack[i]));
    // R3: start never goes to a VP that was running
    p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_q[i] |-> !$past(running[i]));
    // R5: a halt pulse is seen with the status already cleared
    p_halt_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q[i] |-> !running[i]);
  end
endmodule

// File: rtl/vpc_readback.sv
module vpc_readback
  import vpc_pkg::*;
#(
  parameter int unsigned NUM_VP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vpc_op_t           op,
  input  logic [NUM_VP-1:0] running,
  output logic [DATA_W-1:0] rdata,
  output logic              rvld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      rvld  <= 1'b0;
    end else begin
      rvld  <= op.any_rd;
      rdata <= op.stat_rd ? DATA_W'(running) : '0;
    end
  end

  // R9: read-valid only follows a read
  p_rvld_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rvld |-> $past(op.any_rd));
  // R9: data is quiet outside read-valid
  p_quiet_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rvld |-> (rdata == '0));
endmodule

// File: rtl/vp_run_ctrl.sv
module vp_run_ctrl
  import vpc_pkg::*;
#(
  parameter int unsigned NUM_VP = 1,
  parameter logic [63:0] BOOT_MASK = 64'h1,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LOCAL_BASE  = 'h2000,
  parameter logic [ADDR_W-1:0] REMOTE_BASE = 'h4000,
  parameter logic [ADDR_W-1:0] GO_OFS   = 'h0028,
  parameter logic [ADDR_W-1:0] HALT_OFS = 'h0030,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h0038
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_vld,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              bus_rvld,
  output logic [NUM_VP-1:0] vp_start_req,
  output logic [NUM_VP-1:0] vp_halt_req,
  input  logic [NUM_VP-1:0] vp_start_ack
);
  localparam logic [63:0] VP_MASK =
    (NUM_VP >= 64) ? {64{1'b1}} : ((64'd1 << NUM_VP) - 64'd1);

  // R10: boot set must fit the configured VP count
  initial begin
    p_boot_cfg_r10: assert ((BOOT_MASK & ~VP_MASK) == 64'd0)
      else $fatal(1, "BOOT_MASK has bits beyond NUM_VP");
  end

  vpc_op_t           op;
  logic [63:0]       wdata_m;
  logic [NUM_VP-1:0] running;

  assign wdata_m = bus_wdata & VP_MASK;   // R7 masking

  vpc_decode #(
    .ADDR_W(ADDR_W), .LOCAL_BASE(LOCAL_BASE), .REMOTE_BASE(REMOTE_BASE),
    .GO_OFS(GO_OFS), .HALT_OFS(HALT_OFS), .STAT_OFS(STAT_OFS)
  ) u_dec (
    .vld(bus_vld), .wr(bus_wr), .addr(bus_addr), .op(op)
  );

  vpc_state #(.NUM_VP(NUM_VP), .BOOT_MASK(BOOT_MASK)) u_state (
    .clk(clk), .rst_n(rst_n),
    .go_wr(op.go_wr), .halt_wr(op.halt_wr),
    .wmask(wdata_m[NUM_VP-1:0]), .ack(vp_start_ack),
    .running(running), .start_q(vp_start_req), .halt_q(vp_halt_req)
  );

  vpc_readback #(.NUM_VP(NUM_VP)) u_rb (
    .clk(clk), .rst_n(rst_n), .op(op), .running(running),
    .rdata(bus_rdata), .rvld(bus_rvld)
  );

  // R7: bits above the VP count never read back as one
  p_hi_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~VP_MASK) == 64'd0);
endmodule

// File: tb/sim_vp_run_ctrl.sv
`timescale 1ns/1ps
module sim_vp_run_ctrl;
  localparam int NV = 4;
  localparam logic [63:0] BOOT = 64'h5;
  localparam logic [15:0] LB = 16'h2000, RB = 16'h4000;
  localparam logic [15:0] GO = 16'h0028, HLT = 16'h0030, ST = 16'h0038;

  logic clk = 0, rst_n = 0;
  logic bus_vld = 0, bus_wr = 0;
  logic [15:0] bus_addr = 0;
  logic [63:0] bus_wdata = 0, bus_rdata;
  logic bus_rvld;
  logic [NV-1:0] start_req, halt_req, ack = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vp_run_ctrl #(.NUM_VP(NV), .BOOT_MASK(BOOT)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvld(bus_rvld), .vp_start_req(start_req), .vp_halt_req(halt_req),
    .vp_start_ack(ack)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Behavioural reference model
  logic [NV-1:0] m_run = 0, m_start = 0, m_halt = 0;
  logic [63:0] m_rdata = 0;
  logic m_rvld = 0;
  bit m_boot = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_start = 0; m_halt = 0; m_rdata = 0; m_rvld = 0; m_boot = 1;
    end else begin
      logic [NV-1:0] d;
      bit go, hl, sr;
      d  = bus_wdata[NV-1:0];
      go = bus_vld && bus_wr && (bus_addr == LB+GO || bus_addr == RB+GO);
      hl = bus_vld && bus_wr && (bus_addr == LB+HLT || bus_addr == RB+HLT);
      sr = bus_vld && !bus_wr && (bus_addr == LB+ST || bus_addr == RB+ST);
      m_start = (m_boot ? BOOT[NV-1:0] : '0) | (go ? (d & ~m_run) : '0);
      m_boot  = 0;
      m_halt  = hl ? (d & m_run) : '0;
      m_rvld  = bus_vld && !bus_wr;
      m_rdata = sr ? 64'(m_run) : 64'd0;
      for (int i = 0; i < NV; i++) begin
        if (hl && d[i]) m_run[i] = 0;
        else if (ack[i]) m_run[i] = 1;
      end
    end
  end

  always @(negedge clk) if (!done) begin
    check("R3 model start", 64'(start_req), 64'(m_start));
    check("R5 model halt", 64'(halt_req), 64'(m_halt));
    check("R9 model rvld", 64'(bus_rvld), 64'(m_rvld));
    check("R9 model rdata", bus_rdata, m_rdata);
  end

  task automatic cyc(input bit v, input bit w, input logic [15:0] a,
                     input logic [63:0] dd, input logic [NV-1:0] ak);
    bus_vld = v; bus_wr = w; bus_addr = a; bus_wdata = dd; ack = ak;
    @(negedge clk);
    bus_vld = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; ack = 0;
  endtask

  task automatic rd(input logic [15:0] a, input string tag, input logic [63:0] exp);
    cyc(1, 0, a, 0, 0);
    check(tag, 64'(bus_rvld), 64'd1);
    check(tag, bus_rdata, exp);
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 start", 64'(start_req), 0);
    check("R1 halt", 64'(halt_req), 0);
    check("R1 rvld/rdata", {bus_rdata[62:0], bus_rvld}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R2 boot pulse", 64'(start_req), 64'h5);
    cyc(0, 0, 0, 0, 0);
    check("R2 boot single", 64'(start_req), 0);
    rd(LB+ST, "R2 not running before ack", 0);
    cyc(0, 0, 0, 0, 4'b0101);
    rd(LB+ST, "R4 ack sets", 64'h5);
    cyc(1, 1, LB+GO, 64'hFFFF_FFFF_FFFF_FFF3, 0);
    check("R3 R7 start only idle in-range", 64'(start_req), 64'h2);
    cyc(0, 0, 0, 0, 0);
    check("R3 pulse one cycle", 64'(start_req), 0);
    rd(LB+ST, "R4 write does not set", 64'h5);
    cyc(0, 0, 0, 0, 4'b0010);
    rd(RB+ST, "R8 R7 remote status", 64'h7);
    cyc(1, 1, RB+HLT, 64'h11, 0);
    check("R5 R8 halt pulse", 64'(halt_req), 64'h1);
    rd(LB+ST, "R5 cleared", 64'h6);
    cyc(1, 1, LB+HLT, 64'h8, 0);
    check("R5 no halt idle", 64'(halt_req), 0);
    cyc(1, 1, RB+GO, 64'h8, 0);
    check("R8 remote start", 64'(start_req), 64'h8);
    cyc(1, 1, LB+HLT, 64'h8, 4'b1000);
    rd(LB+ST, "R6 halt beats ack", 64'h6);
    cyc(0, 0, 0, 0, 4'b1000);
    rd(LB+ST, "R4 later ack", 64'hE);
    cyc(1, 1, LB+GO+4, 64'h1, 0);
    check("R9 unmapped write", 64'(start_req), 0);
    cyc(1, 1, LB+ST, 64'hF, 0);
    check("R9 status write ignored", 64'({start_req, halt_req}), 0);
    rd(LB+16'h100, "R9 unmapped read", 0);
    rd(RB+GO, "R9 go offset reads zero", 0);
    rd(RB+ST, "R9 status intact", 64'hE);
    cyc(0, 0, 0, 0, 0);
    finish_run();
  end
endmodule